// File: doc/BRIEF.md
# Software Interrupt Generation Controller

This block raises inter-processor software interrupts inside a cluster of up to eight cores. A core posts a request by writing a single 32-bit generate register. The write carries an interrupt number, an explicit list of target cores and a two-bit filter. The filter either uses the list as given, sends to every online core except the writer, or sends to the writer alone. Every core that is hit marks that interrupt pending and records the writer in a per-interrupt source mask. The block therefore remembers each core that has raised the interrupt, not only the fact that it was raised.

Two 16-byte windows give each core a view of its own source masks, one byte per interrupt number. Reads from either window return the masks. Writes to the clear window remove source bits, and writes to the set window add them. The pending flags and source masks of every core leave the block as flat vectors for a downstream delivery stage. A one-cycle notification pulse per core marks each new pending interrupt. The bus allows byte and aligned word accesses. Read data is registered and appears one cycle after the request.

Top module: `swint_ctrl`

## Requirements
- R1: When `rst_n` is low at a clock edge, every pending flag, source mask, notification and `bus_rdata` is cleared.
- R2: A word write (`bus_size`=1) to address 0x00 takes the interrupt number from bits [3:0], the target list from bits [23:16] (bit k = core k) and the filter from bits [25:24]. Filter 0 sends to the listed cores. Each targeted core gets that interrupt pending and the writer's bit (`req_core`) set in its source mask. Existing pending state is never cleared by a generate write.
- R3: Filter 1 targets every online core except the writer, and the list field is ignored.
- R4: Filter 2 targets only the writer.
- R5: Filter 3 is reserved. Such a write changes no pending flag, no mask and no notification.
- R6: A core whose index is greater than or equal to `online_cnt` is never targeted, even when it is named in the list.
- R7: A read anywhere in 0x00–0x0F returns zero.
- R8: A byte read at 0x10+n or 0x20+n returns the source mask of interrupt n of core `req_core`. A word read at an aligned address packs interrupts n..n+3 into bytes 0..3.
- R9: A write to the clear window 0x10–0x1F clears the written bits in the addressed masks of core `req_core`. Byte lanes of a word write map to consecutive interrupts. The pending flag falls only when the mask becomes zero.
- R10: A write to the set window 0x20–0x2F ORs the written bits into the addressed masks of core `req_core`. The flag becomes pending only if the resulting mask is nonzero. A word access whose address is not a multiple of 4 is ignored.
- R11: `core_notify[c]` is high for exactly the one cycle after an edge at which any interrupt of core c went from not pending to pending. It stays low when an interrupt that is already pending is raised again.
- R12: Window writes change only the banks of core `req_core`. The state of other cores is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 1 | 0 = byte, 1 = word |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data (byte access uses bits [7:0]) |
| bus_rdata | output | 32 | Registered read data |
| req_core | input | 3 | Index of the accessing core |
| online_cnt | input | 4 | Number of online cores |
| pend_flags | output | 128 | Pending flag, bit c*16+n = core c, interrupt n |
| src_masks | output | 1024 | Source mask, bits (c*16+n)*8 +: 8 |
| core_notify | output | 8 | One-cycle new-pending pulse per core |

## Verification
The generate register is driven with all four filter values and varied online counts. Writer positions are chosen so that the explicit list, the all-but-writer set, the writer alone and the reserved code give target sets that cannot be confused with one another. Lists that name offline cores separate the online clipping from the filter decode. Several writers raising the same interrupt for one core show that sources accumulate as a mask rather than overwriting each other. Partial clears then show that the flag stays up until the last source bit is gone. Set-window writes with zero and nonzero bytes, word reads that pack neighbouring interrupts, and accesses from a different core tell the byte-lane mapping and the per-core bank selection apart.

// File: rtl/swint_pkg.sv
package swint_pkg;

    localparam int ADDR_W       = 6;
    localparam int GEN_LIST_LSB = 16;
    localparam int GEN_MODE_LSB = 24;

    localparam logic [1:0] REGION_GEN = 2'd0;
    localparam logic [1:0] REGION_CLR = 2'd1;
    localparam logic [1:0] REGION_SET = 2'd2;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_GEN  = 2'd1,
        OP_CLR  = 2'd2,
        OP_SET  = 2'd3
    } swint_op_e;

    typedef enum logic [1:0] {
        TGT_LIST   = 2'd0,
        TGT_OTHERS = 2'd1,
        TGT_SELF   = 2'd2,
        TGT_RSVD   = 2'd3
    } tgt_mode_e;

    typedef struct packed {
        logic [31:0] rdata;
    } top_state_t;

endpackage

// File: rtl/swint_bus_dec.sv
module swint_bus_dec
    import swint_pkg::*;
#(
    parameter int NUM_IDS = 16,
    localparam int ID_W   = $clog2(NUM_IDS)
) (
    input  logic                          bus_req,
    input  logic                          bus_we,
    input  logic                          bus_size,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [31:0]                   bus_wdata,
    output swint_op_e                     op,
    output logic                          rd_acc,
    output logic                          rd_win,
    output logic                          rd_word,
    output logic [ID_W-1:0]               rd_id,
    output logic [NUM_IDS-1:0]            id_sel,
    output logic [NUM_IDS-1:0][7:0]       id_byte
);

    logic [1:0]      region;
    logic [ID_W-1:0] offset;
    logic            access_ok;

    assign region    = bus_addr[ADDR_W-1:ADDR_W-2];
    assign offset    = bus_addr[ID_W-1:0];
    assign access_ok = !bus_size || (bus_addr[1:0] == 2'b00);

    always_comb begin
        op      = OP_NONE;
        rd_acc  = bus_req && !bus_we;
        rd_win  = 1'b0;
        rd_word = bus_size;
        rd_id   = offset;
        id_sel  = '0;
        id_byte = '0;
        if (bus_req && access_ok) begin
            unique case (region)
                REGION_GEN: begin
                    if (bus_we && bus_size && bus_addr == '0) begin
                        op = OP_GEN;
                    end
                end
                REGION_CLR, REGION_SET: begin
                    if (bus_we) begin
                        op = (region == REGION_CLR) ? OP_CLR : OP_SET;
                    end else begin
                        rd_win = 1'b1;
                    end
                end
                default: begin
                    op = OP_NONE;
                end
            endcase
            if (bus_we && (region == REGION_CLR || region == REGION_SET)) begin
                for (int k = 0; k < 4; k++) begin
                    if (bus_size || k == 0) begin
                        id_sel[offset + ID_W'(k)]  = 1'b1;
                        id_byte[offset + ID_W'(k)] = bus_wdata[8*k +: 8];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/swint_target_dec.sv
module swint_target_dec
    import swint_pkg::*;
#(
    parameter int NUM_CORES = 8,
    localparam int CORE_W   = $clog2(NUM_CORES),
    localparam int CNT_W    = $clog2(NUM_CORES + 1)
) (
    input  logic [1:0]            mode,
    input  logic [NUM_CORES-1:0]  list,
    input  logic [CORE_W-1:0]     req_core,
    input  logic [CNT_W-1:0]      online_cnt,
    output logic [NUM_CORES-1:0]  targets
);

    logic [NUM_CORES-1:0] online;
    logic [NUM_CORES-1:0] self_bit;

    always_comb begin
        for (int c = 0; c < NUM_CORES; c++) begin
            online[c]   = (CNT_W'(c) < online_cnt);
            self_bit[c] = (req_core == CORE_W'(c));
        end
    end

    always_comb begin
        unique case (tgt_mode_e'(mode))
            TGT_LIST:   targets = list & online;
            TGT_OTHERS: targets = online & ~self_bit;
            TGT_SELF:   targets = self_bit & online;
            default:    targets = '0;
        endcase
    end

endmodule

// File: rtl/swint_core_bank.sv
module swint_core_bank #(
    parameter int NUM_CORES = 8,
    parameter int NUM_IDS   = 16,
    localparam int CORE_W   = $clog2(NUM_CORES),
    localparam int ID_W     = $clog2(NUM_IDS)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  gen_hit,
    input  logic [ID_W-1:0]                       gen_id,
    input  logic                                  win_clr,
    input  logic                                  win_set,
    input  logic [NUM_IDS-1:0]                    id_sel,
    input  logic [NUM_IDS-1:0][7:0]               id_byte,
    input  logic [CORE_W-1:0]                     req_core,
    output logic [NUM_IDS-1:0][NUM_CORES-1:0]     masks,
    output logic [NUM_IDS-1:0]                    pend,
    output logic                                  notify
);

    typedef struct packed {
        logic [NUM_IDS-1:0][NUM_CORES-1:0] masks;
        logic [NUM_IDS-1:0]                pend;
        logic                              notify;
    } bank_state_t;

    bank_state_t          st_d;
    bank_state_t          st_q;
    logic [NUM_CORES-1:0] src_bit;

    assign src_bit = NUM_CORES'(1) << req_core;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_IDS; i++) begin
            if (gen_hit && gen_id == ID_W'(i)) begin
                st_d.masks[i] = st_d.masks[i] | src_bit;
                st_d.pend[i]  = 1'b1;
            end
            if (win_clr && id_sel[i]) begin
                st_d.masks[i] = st_d.masks[i] & ~id_byte[i][NUM_CORES-1:0];
                if (st_d.masks[i] == '0) begin
                    st_d.pend[i] = 1'b0;
                end
            end
            if (win_set && id_sel[i]) begin
                st_d.masks[i] = st_d.masks[i] | id_byte[i][NUM_CORES-1:0];
                if (st_d.masks[i] != '0) begin
                    st_d.pend[i] = 1'b1;
                end
            end
        end
        st_d.notify = |(st_d.pend & ~st_q.pend);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign masks  = st_q.masks;
    assign pend   = st_q.pend;
    assign notify = st_q.notify;

endmodule

// File: rtl/swint_ctrl.sv
module swint_ctrl
    import swint_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int NUM_IDS   = 16,
    localparam int CORE_W   = $clog2(NUM_CORES),
    localparam int CNT_W    = $clog2(NUM_CORES + 1),
    localparam int ID_W     = $clog2(NUM_IDS),
    localparam int PEND_W   = NUM_CORES * NUM_IDS,
    localparam int MASK_W   = NUM_CORES * NUM_IDS * NUM_CORES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic                 bus_size,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [CORE_W-1:0]    req_core,
    input  logic [CNT_W-1:0]     online_cnt,
    output logic [PEND_W-1:0]    pend_flags,
    output logic [MASK_W-1:0]    src_masks,
    output logic [NUM_CORES-1:0] core_notify
);

    swint_op_e                    op;
    logic                         rd_acc;
    logic                         rd_win;
    logic                         rd_word;
    logic [ID_W-1:0]              rd_id;
    logic [NUM_IDS-1:0]           id_sel;
    logic [NUM_IDS-1:0][7:0]      id_byte;
    logic [NUM_CORES-1:0]         targets;

    logic [NUM_IDS-1:0][NUM_CORES-1:0] bank_masks [NUM_CORES];
    logic [NUM_IDS-1:0]                bank_pend  [NUM_CORES];
    logic [NUM_IDS-1:0][NUM_CORES-1:0] own_masks;

    top_state_t st_d;
    top_state_t st_q;

    swint_bus_dec #(
        .NUM_IDS (NUM_IDS)
    ) u_bus (
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .op        (op),
        .rd_acc    (rd_acc),
        .rd_win    (rd_win),
        .rd_word   (rd_word),
        .rd_id     (rd_id),
        .id_sel    (id_sel),
        .id_byte   (id_byte)
    );

    swint_target_dec #(
        .NUM_CORES (NUM_CORES)
    ) u_tgt (
        .mode       (bus_wdata[GEN_MODE_LSB +: 2]),
        .list       (bus_wdata[GEN_LIST_LSB +: NUM_CORES]),
        .req_core   (req_core),
        .online_cnt (online_cnt),
        .targets    (targets)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_bank
        logic is_self;
        assign is_self = (req_core == CORE_W'(c));

        swint_core_bank #(
            .NUM_CORES (NUM_CORES),
            .NUM_IDS   (NUM_IDS)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .gen_hit  ((op == OP_GEN) && targets[c]),
            .gen_id   (bus_wdata[ID_W-1:0]),
            .win_clr  ((op == OP_CLR) && is_self),
            .win_set  ((op == OP_SET) && is_self),
            .id_sel   (id_sel),
            .id_byte  (id_byte),
            .req_core (req_core),
            .masks    (bank_masks[c]),
            .pend     (bank_pend[c]),
            .notify   (core_notify[c])
        );

        assign src_masks[c*NUM_IDS*NUM_CORES +: NUM_IDS*NUM_CORES] = bank_masks[c];
        assign pend_flags[c*NUM_IDS +: NUM_IDS]                    = bank_pend[c];
    end

    assign own_masks = bank_masks[req_core];

    always_comb begin
        st_d = st_q;
        if (rd_acc) begin
            st_d.rdata = '0;
            if (rd_win) begin
                for (int k = 0; k < 4; k++) begin
                    if (rd_word || k == 0) begin
                        st_d.rdata[8*k +: 8] = 8'(own_masks[rd_id + ID_W'(k)]);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/swint_ctrl_chk.sv
module swint_ctrl_chk #(
    parameter int NUM_CORES = 8,
    parameter int NUM_IDS   = 16,
    localparam int CORE_W   = $clog2(NUM_CORES),
    localparam int CNT_W    = $clog2(NUM_CORES + 1),
    localparam int PEND_W   = NUM_CORES * NUM_IDS,
    localparam int MASK_W   = NUM_CORES * NUM_IDS * NUM_CORES
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_req,
    input logic                 bus_we,
    input logic                 bus_size,
    input logic [5:0]           bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [CORE_W-1:0]    req_core,
    input logic [CNT_W-1:0]     online_cnt,
    input logic [PEND_W-1:0]    pend_flags,
    input logic [MASK_W-1:0]    src_masks,
    input logic [NUM_CORES-1:0] core_notify
);

    logic [PEND_W-1:0] mask_nz;
    logic              gen_wr;

    always_comb begin
        for (int j = 0; j < PEND_W; j++) begin
            mask_nz[j] = |src_masks[j*NUM_CORES +: NUM_CORES];
        end
    end

    assign gen_wr = bus_req && bus_we && bus_size && bus_addr == 6'd0;

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (pend_flags == '0 && src_masks == '0 && core_notify == '0 && bus_rdata == '0));

    assert_gen_keeps_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gen_wr |=> ((pend_flags & $past(pend_flags)) == $past(pend_flags)));

    assert_reserved_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_wr && bus_wdata[25:24] == 2'b11) |=> ($stable(pend_flags) && $stable(src_masks)));

    assert_gen_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr[5:4] == 2'b00) |=> (bus_rdata == '0));

    // R9 and R10: a flag is pending exactly when its source mask is nonzero
    assert_pend_tracks_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pend_flags == mask_nz);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assert_notify_on_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
            core_notify[c] |->
                ((pend_flags[c*NUM_IDS +: NUM_IDS] & ~$past(pend_flags[c*NUM_IDS +: NUM_IDS])) != '0));
    end

endmodule

bind swint_ctrl swint_ctrl_chk #(
    .NUM_CORES (NUM_CORES),
    .NUM_IDS   (NUM_IDS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_size    (bus_size),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .req_core    (req_core),
    .online_cnt  (online_cnt),
    .pend_flags  (pend_flags),
    .src_masks   (src_masks),
    .core_notify (core_notify)
);

// File: tb/swint_ctrl_tb.sv
module swint_ctrl_tb;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic          bus_size = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [2:0]    req_core = '0;
    logic [3:0]    online_cnt = 4'd8;
    logic [127:0]  pend_flags;
    logic [1023:0] src_masks;
    logic [7:0]    core_notify;

    int   n_checks = 0;
    int   n_fail   = 0;
    logic [7:0] last_notify;
    bit   finished = 0;

    always #4 clk = ~clk;

    swint_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_size    (bus_size),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .req_core    (req_core),
        .online_cnt  (online_cnt),
        .pend_flags  (pend_flags),
        .src_masks   (src_masks),
        .core_notify (core_notify)
    );

    function automatic logic [7:0] mask_of(int c, int id);
        return src_masks[(c*16 + id)*8 +: 8];
    endfunction

    function automatic logic pend_of(int c, int id);
        return pend_flags[c*16 + id];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(logic [5:0] a, logic sz, logic [31:0] d, int core);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_size = sz;
        bus_addr = a; bus_wdata = d; req_core = 3'(core);
        @(negedge clk);
        last_notify = core_notify;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [5:0] a, logic sz, int core, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_size = sz;
        bus_addr = a; req_core = 3'(core);
        @(negedge clk);
        d = bus_rdata;
        bus_req = 1'b0;
    endtask

    function automatic logic [31:0] gen_word(int mode, int list, int id);
        return (32'(mode) << 24) | (32'(list) << 16) | 32'h0000_FF00 | 32'(id);
    endfunction

    task automatic t_reset();
        do_reset();
        check("R1 pend", 32'(pend_flags != '0), 0);
        check("R1 masks", 32'(src_masks != '0), 0);
        check("R1 notify", 32'(core_notify), 0);
        check("R1 rdata", bus_rdata, 0);
    endtask

    task automatic t_explicit();
        do_reset();
        online_cnt = 4'd8;
        bus_write(6'h00, 1'b1, gen_word(0, 8'h91, 5), 2);
        check("R2 pend c0", 32'(pend_of(0, 5)), 1);
        check("R2 pend c4", 32'(pend_of(4, 5)), 1);
        check("R2 pend c7", 32'(pend_of(7, 5)), 1);
        check("R2 not c1", 32'(pend_of(1, 5)), 0);
        check("R2 mask c4", 32'(mask_of(4, 5)), 32'h04);
        check("R11 notify", 32'(last_notify), 32'h91);
        @(negedge clk);
        check("R11 one cycle", 32'(core_notify), 0);
        bus_write(6'h00, 1'b1, gen_word(0, 8'h01, 5), 2);
        check("R11 no renotify", 32'(last_notify), 0);
        check("R2 mask kept", 32'(mask_of(0, 5)), 32'h04);
    endtask

    task automatic t_others();
        do_reset();
        online_cnt = 4'd5;
        bus_write(6'h00, 1'b1, gen_word(1, 8'hFF, 3), 1);
        check("R3 targets", {24'b0, pend_of(7,3), pend_of(6,3), pend_of(5,3), pend_of(4,3),
                             pend_of(3,3), pend_of(2,3), pend_of(1,3), pend_of(0,3)}, 32'h1D);
        check("R3 mask c2", 32'(mask_of(2, 3)), 32'h02);
        check("R11 notify others", 32'(last_notify), 32'h1D);
    endtask

    task automatic t_self();
        do_reset();
        online_cnt = 4'd8;
        bus_write(6'h00, 1'b1, gen_word(2, 8'h01, 9), 6);
        check("R4 self pend", 32'(pend_of(6, 9)), 1);
        check("R4 self mask", 32'(mask_of(6, 9)), 32'h40);
        check("R4 list ignored", 32'(pend_of(0, 9)), 0);
    endtask

    task automatic t_reserved();
        do_reset();
        online_cnt = 4'd8;
        bus_write(6'h00, 1'b1, gen_word(3, 8'hFF, 1), 3);
        check("R5 no pend", 32'(pend_flags != '0), 0);
        check("R5 no mask", 32'(src_masks != '0), 0);
        check("R5 no notify", 32'(last_notify), 0);
    endtask

    task automatic t_offline();
        do_reset();
        online_cnt = 4'd3;
        bus_write(6'h00, 1'b1, gen_word(0, 8'hFF, 2), 0);
        check("R6 online", {29'b0, pend_of(2,2), pend_of(1,2), pend_of(0,2)}, 32'h7);
        check("R6 offline", {27'b0, pend_of(7,2), pend_of(6,2), pend_of(5,2), pend_of(4,2), pend_of(3,2)}, 0);
        online_cnt = 4'd8;
    endtask

    task automatic t_window();
        logic [31:0] rd;
        do_reset();
        online_cnt = 4'd8;
        bus_write(6'h00, 1'b1, gen_word(0, 8'h08, 4), 0);
        bus_write(6'h00, 1'b1, gen_word(0, 8'h08, 4), 5);
        bus_write(6'h00, 1'b1, gen_word(0, 8'h08, 6), 1);
        bus_read(6'h00, 1'b1, 3, rd);
        check("R7 gen reads zero", rd, 0);
        bus_read(6'h04, 1'b1, 3, rd);
        check("R7 gen region zero", rd, 0);
        bus_read(6'h14, 1'b0, 3, rd);
        check("R8 byte clr win", rd, 32'h21);
        bus_read(6'h24, 1'b0, 3, rd);
        check("R8 byte set win", rd, 32'h21);
        bus_read(6'h14, 1'b1, 3, rd);
        check("R8 word pack", rd, 32'h0002_0021);
        bus_read(6'h14, 1'b0, 2, rd);
        check("R8 other core", rd, 0);
        bus_write(6'h14, 1'b0, 32'h01, 3);
        check("R9 partial mask", 32'(mask_of(3, 4)), 32'h20);
        check("R9 still pend", 32'(pend_of(3, 4)), 1);
        bus_write(6'h14, 1'b0, 32'h20, 3);
        check("R9 cleared pend", 32'(pend_of(3, 4)), 0);
        bus_write(6'h14, 1'b1, 32'h0002_0000, 3);
        check("R9 word lane clear", {pend_of(3, 6), mask_of(3, 6)}, 0);
    endtask

    task automatic t_set();
        do_reset();
        bus_write(6'h28, 1'b1, 32'h0000_8000, 2);
        check("R10 set pend", 32'(pend_of(2, 9)), 1);
        check("R10 set mask", 32'(mask_of(2, 9)), 32'h80);
        check("R10 zero lane", 32'(pend_of(2, 8)), 0);
        check("R11 set notify", 32'(last_notify), 32'h04);
        bus_write(6'h2F, 1'b0, 32'h00, 2);
        check("R10 zero byte", 32'(pend_of(2, 15)), 0);
        bus_write(6'h22, 1'b1, 32'hFFFF_FFFF, 2);
        check("R10 misaligned", {pend_of(2,3), pend_of(2,2), mask_of(2, 2)}, 0);
    endtask

    task automatic t_isolation();
        do_reset();
        bus_write(6'h29, 1'b0, 32'h80, 5);
        bus_write(6'h29, 1'b0, 32'h80, 2);
        bus_write(6'h19, 1'b0, 32'hFF, 2);
        check("R12 own cleared", {pend_of(2, 9), mask_of(2, 9)}, 0);
        check("R12 other kept", {pend_of(5, 9), mask_of(5, 9)}, 32'h180);
    endtask

    initial begin
        t_reset();
        t_explicit();
        t_others();
        t_self();
        t_reserved();
        t_offline();
        t_window();
        t_set();
        t_isolation();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule